// File: doc/BRIEF.md
# Framed Packet Deserializer Decoder

The block takes a serial line, one bit per clock, and turns framed packets back into bytes. It hunts for a 32-bit sync word at any bit offset. It then parses a start-of-frame packet that carries a destination address, a byte count and a CRC. After that it parses a data packet that carries the payload bytes and a second CRC. Payload bytes leave on a RAM write port, starting at address 0.

Every packet identifier byte carries its own check nibble. A broken identifier sets a sticky flag and sends the decoder back to hunting. Both CRCs are checked. The result of each frame is reported by a one-cycle done pulse, together with a pass or fail bit and a sticky CRC error flag.

Top module: `fpd_decoder`

## Requirements
- R1: Parsing starts only after the 32 bits 0xAAAA5555 have arrived MSB first on `bit_i`, at any bit offset. A partial sync word starts nothing.
- R2: A packet identifier byte is valid only when its low nibble is the bitwise inverse of its high nibble. An invalid identifier sets `pid_err_o`, which stays set until reset. The decoder then returns to hunting and gives no done pulse and no further writes for that frame.
- R3: The first packet after sync has identifier 0x1E. It is followed by a 32-bit address, a 16-bit length and a 16-bit CRC, each MSB first. On a good CRC, `addr_o` and `len_o` take the new values.
- R4: Exactly `len_o` payload bytes are written, at RAM addresses 0, 1, 2 and so on, each byte assembled MSB first. Each write is a one-cycle `ram_we_o` pulse.
- R5: Both CRCs are CRC-16 with polynomial 0x1021 and initial value 0xFFFF, with no reflection and no final inversion. The first covers address and length. The second covers the payload bytes. Each is sent MSB first.
- R6: The second packet has identifier 0x2D and carries the payload and then its CRC. A good payload CRC gives a one-cycle `frame_done_o` pulse with `frame_ok_o` high.
- R7: A bad payload CRC sets sticky `crc_err_o` and gives `frame_done_o` with `frame_ok_o` low. Bytes already written stay written.
- R8: A bad start-of-frame CRC sets `crc_err_o` and gives `frame_done_o` with `frame_ok_o` low. No payload bytes are written, and `addr_o` and `len_o` keep their previous values.
- R9: A valid identifier of the wrong type, in either packet position, aborts the frame silently. It sets no flag, gives no done pulse and writes nothing, and the decoder hunts for the next sync.
- R10: A length of 0 writes nothing. The empty payload's CRC is 0xFFFF, and a good one gives a passing done pulse.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial line bit |
| ram_we_o | output | 1 | Payload RAM write strobe |
| ram_addr_o | output | RAM_AW | Payload RAM byte address |
| ram_data_o | output | 8 | Payload byte |
| addr_o | output | 32 | Address from the last good start-of-frame packet |
| len_o | output | 16 | Length from the last good start-of-frame packet |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |
| frame_ok_o | output | 1 | Frame passed both CRCs; valid with `frame_done_o` |
| pid_err_o | output | 1 | Sticky identifier check error |
| crc_err_o | output | 1 | Sticky CRC error |

## Verification
Good frames are sent after an odd number of noise bits. This separates true bit alignment from alignment that only works on byte boundaries. A sync word with its last bit missing shows that a partial match starts nothing.

Frames of length 5 and length 0 separate the payload path from the path that goes straight to the payload CRC. Single-bit corruption of each CRC in turn shows which CRC gates the address latch and which gates the RAM writes. Identifiers that are corrupted, or valid but of the wrong type, separate the flagged abort from the silent abort. A good frame after each fault shows that the decoder went back to hunting.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int SYNC_W  = 32;
  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 16;
  localparam int CRC_W   = 16;
  localparam int PID_W   = 8;
  localparam int BYTE_W  = 8;

  localparam logic [SYNC_W-1:0] SYNC_WORD = 32'hAAAA5555;
  localparam logic [CRC_W-1:0]  CRC_POLY  = 16'h1021;
  localparam logic [CRC_W-1:0]  CRC_INIT  = 16'hFFFF;
  localparam logic [3:0]        TYPE_SOF  = 4'h1;
  localparam logic [3:0]        TYPE_DAT  = 4'h2;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SOF_PID,
    ST_SOF_BODY,
    ST_DAT_PID,
    ST_PAYLOAD,
    ST_DAT_CRC
  } fpd_state_e;

  function automatic logic pid_valid(input logic [PID_W-1:0] pid);
    return pid[3:0] == ~pid[7:4];
  endfunction
endpackage

// File: rtl/fpd_sync_hunt.sv
module fpd_sync_hunt #(
  parameter int              W       = 32,
  parameter logic [W-1:0]    PATTERN = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic hit_o
);
  logic [W-2:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[W-3:0], bit_i};
  end

  // Match includes the bit on the line this cycle.
  assign hit_o = ({hist_q, bit_i} == PATTERN);
endmodule

// File: rtl/fpd_crc_serial.sv
module fpd_crc_serial #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = '0,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb    = crc_q[W-1] ^ bit_i;
  assign nxt_o = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= INIT;
    else if (clr_i) crc_q <= INIT;
    else if (en_i)  crc_q <= nxt_o;
  end
endmodule

// File: rtl/fpd_ctrl.sv
module fpd_ctrl
  import fpd_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bit_i,
  input  logic                  sync_hit_i,
  input  logic [CRC_W-1:0]      crc_nxt_i,
  output logic                  crc_clr_o,
  output logic                  crc_en_o,
  output logic                  ram_we_o,
  output logic [RAM_AW-1:0]     ram_addr_o,
  output logic [BYTE_W-1:0]     ram_data_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [LEN_W-1:0]      len_o,
  output logic                  frame_done_o,
  output logic                  frame_ok_o,
  output logic                  pid_err_o,
  output logic                  crc_err_o
);
  localparam int FIELD_BITS = ADDR_W + LEN_W;
  localparam int SOF_BITS   = FIELD_BITS + CRC_W;
  localparam int CNT_W      = $clog2(SOF_BITS);
  localparam logic [CNT_W-1:0] LAST_PID  = CNT_W'(PID_W - 1);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_CRC  = CNT_W'(CRC_W - 1);
  localparam logic [CNT_W-1:0] LAST_SOF  = CNT_W'(SOF_BITS - 1);
  localparam logic [CNT_W-1:0] FIELD_END = CNT_W'(FIELD_BITS);

  fpd_state_e              state_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [FIELD_BITS-1:0]   shreg_q;
  logic [LEN_W-1:0]        bidx_q;
  logic [BYTE_W-1:0]       byte_w;
  logic                    shift_en;
  logic                    crc_zero;

  assign byte_w   = {shreg_q[BYTE_W-2:0], bit_i};
  // Freeze fields while the SOF CRC bits pass.
  assign shift_en = !(state_q == ST_SOF_BODY && cnt_q >= FIELD_END);
  assign crc_zero = (crc_nxt_i == '0);

  assign crc_clr_o = (state_q == ST_SOF_PID) || (state_q == ST_DAT_PID);
  assign crc_en_o  = (state_q == ST_SOF_BODY) || (state_q == ST_PAYLOAD) ||
                     (state_q == ST_DAT_CRC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_HUNT;
      cnt_q        <= '0;
      shreg_q      <= '0;
      bidx_q       <= '0;
      ram_we_o     <= 1'b0;
      ram_addr_o   <= '0;
      ram_data_o   <= '0;
      addr_o       <= '0;
      len_o        <= '0;
      frame_done_o <= 1'b0;
      frame_ok_o   <= 1'b0;
      pid_err_o    <= 1'b0;
      crc_err_o    <= 1'b0;
    end else begin
      ram_we_o     <= 1'b0;
      frame_done_o <= 1'b0;
      frame_ok_o   <= 1'b0;
      if (shift_en) shreg_q <= {shreg_q[FIELD_BITS-2:0], bit_i};
      cnt_q <= cnt_q + 1'b1;

      unique case (state_q)
        ST_HUNT: begin
          cnt_q <= '0;
          if (sync_hit_i) state_q <= ST_SOF_PID;
        end

        ST_SOF_PID: begin
          if (cnt_q == LAST_PID) begin
            cnt_q <= '0;
            if (!pid_valid(byte_w)) begin
              pid_err_o <= 1'b1;
              state_q   <= ST_HUNT;
            end else if (byte_w[7:4] == TYPE_SOF) begin
              state_q <= ST_SOF_BODY;
            end else begin
              state_q <= ST_HUNT;
            end
          end
        end

        ST_SOF_BODY: begin
          if (cnt_q == LAST_SOF) begin
            cnt_q <= '0;
            if (crc_zero) begin
              addr_o  <= shreg_q[FIELD_BITS-1:LEN_W];
              len_o   <= shreg_q[LEN_W-1:0];
              bidx_q  <= '0;
              state_q <= ST_DAT_PID;
            end else begin
              crc_err_o    <= 1'b1;
              frame_done_o <= 1'b1;
              state_q      <= ST_HUNT;
            end
          end
        end

        ST_DAT_PID: begin
          if (cnt_q == LAST_PID) begin
            cnt_q <= '0;
            if (!pid_valid(byte_w)) begin
              pid_err_o <= 1'b1;
              state_q   <= ST_HUNT;
            end else if (byte_w[7:4] == TYPE_DAT) begin
              state_q <= (len_o == '0) ? ST_DAT_CRC : ST_PAYLOAD;
            end else begin
              state_q <= ST_HUNT;
            end
          end
        end

        ST_PAYLOAD: begin
          if (cnt_q == LAST_BYTE) begin
            cnt_q      <= '0;
            ram_we_o   <= 1'b1;
            ram_data_o <= byte_w;
            ram_addr_o <= bidx_q[RAM_AW-1:0];
            bidx_q     <= bidx_q + 1'b1;
            if (bidx_q == len_o - 1'b1) state_q <= ST_DAT_CRC;
          end
        end

        ST_DAT_CRC: begin
          if (cnt_q == LAST_CRC) begin
            cnt_q        <= '0;
            frame_done_o <= 1'b1;
            frame_ok_o   <= crc_zero;
            if (!crc_zero) crc_err_o <= 1'b1;
            state_q      <= ST_HUNT;
          end
        end

        default: state_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/fpd_decoder.sv
module fpd_decoder
  import fpd_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [7:0]        ram_data_o,
  output logic [31:0]       addr_o,
  output logic [15:0]       len_o,
  output logic              frame_done_o,
  output logic              frame_ok_o,
  output logic              pid_err_o,
  output logic              crc_err_o
);
  logic             sync_hit;
  logic             crc_clr;
  logic             crc_en;
  logic [CRC_W-1:0] crc_nxt;

  fpd_sync_hunt #(.W(SYNC_W), .PATTERN(SYNC_WORD)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (bit_i),
    .hit_o  (sync_hit)
  );

  fpd_crc_serial #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .en_i   (crc_en),
    .bit_i  (bit_i),
    .nxt_o  (crc_nxt)
  );

  fpd_ctrl #(.RAM_AW(RAM_AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_i        (bit_i),
    .sync_hit_i   (sync_hit),
    .crc_nxt_i    (crc_nxt),
    .crc_clr_o    (crc_clr),
    .crc_en_o     (crc_en),
    .ram_we_o     (ram_we_o),
    .ram_addr_o   (ram_addr_o),
    .ram_data_o   (ram_data_o),
    .addr_o       (addr_o),
    .len_o        (len_o),
    .frame_done_o (frame_done_o),
    .frame_ok_o   (frame_ok_o),
    .pid_err_o    (pid_err_o),
    .crc_err_o    (crc_err_o)
  );
endmodule

// File: rtl/fpd_decoder_chk.sv
module fpd_decoder_chk #(
  parameter int RAM_AW = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ram_we_o,
  input logic [RAM_AW-1:0] ram_addr_o,
  input logic              frame_done_o,
  input logic              frame_ok_o,
  input logic              pid_err_o,
  input logic              crc_err_o
);
  // A byte takes eight line bits, so strobes never touch.
  assert_we_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !ram_we_o);

  // Consecutive writes step the address by one.
  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && $past(ram_we_o, 8)) |-> ram_addr_o == $past(ram_addr_o, 8) + 1'b1);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  assert_ok_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |-> frame_done_o);

  assert_pid_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pid_err_o |=> pid_err_o);

  assert_crc_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |=> crc_err_o);

  assert_fail_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_o && !frame_ok_o) |-> crc_err_o);
endmodule

bind fpd_decoder fpd_decoder_chk #(.RAM_AW(RAM_AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ram_we_o     (ram_we_o),
  .ram_addr_o   (ram_addr_o),
  .frame_done_o (frame_done_o),
  .frame_ok_o   (frame_ok_o),
  .pid_err_o    (pid_err_o),
  .crc_err_o    (crc_err_o)
);

// File: tb/sim_fpd_decoder.sv
`timescale 1ns/1ps
module sim_fpd_decoder;
  localparam int RAM_AW = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bit_i = 1'b0;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [7:0]        ram_data;
  logic [31:0]       addr;
  logic [15:0]       len;
  logic              done, ok, pid_err, crc_err;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic        fq[$];
  logic [15:0] tcrc;
  logic [7:0]  pay[256];
  logic [7:0]  seen[256];
  int          wr_cnt, done_cnt;
  logic        last_ok;

  always #2.5 clk = ~clk;

  fpd_decoder #(.RAM_AW(RAM_AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_i),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_data_o(ram_data),
    .addr_o(addr), .len_o(len), .frame_done_o(done), .frame_ok_o(ok),
    .pid_err_o(pid_err), .crc_err_o(crc_err)
  );

  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      seen[ram_addr[7:0]] = ram_data;
      wr_cnt++;
    end
    if (rst_n && done) begin
      done_cnt++;
      last_ok = ok;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_obs();
    wr_cnt = 0; done_cnt = 0; last_ok = 1'b0;
    for (int i = 0; i < 256; i++) seen[i] = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_obs();
  endtask

  task automatic push(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) fq.push_back(v[i]);
  endtask

  task automatic pushc(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      logic fb;
      fb = tcrc[15] ^ v[i];
      tcrc = {tcrc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      fq.push_back(v[i]);
    end
  endtask

  task automatic send();
    while (fq.size() > 0) begin
      @(negedge clk);
      bit_i = fq.pop_front();
    end
    repeat (24) begin
      @(negedge clk);
      bit_i = 1'b0;
    end
  endtask

  task automatic build(input logic [31:0] a, input int n, input logic [7:0] sof_pid,
                       input logic [7:0] dat_pid, input logic [15:0] sof_flip,
                       input logic [15:0] dat_flip);
    push(32'hAAAA5555, 32);
    push(sof_pid, 8);
    tcrc = 16'hFFFF;
    pushc(a, 32);
    pushc(n, 16);
    push(tcrc ^ sof_flip, 16);
    push(dat_pid, 8);
    tcrc = 16'hFFFF;
    for (int i = 0; i < n; i++) pushc(pay[i], 8);
    push(tcrc ^ dat_flip, 16);
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 256; i++) pay[i] = 8'((i * 37 + seed) & 8'hFF);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 we", ram_we, 0);
    chk("R11 addr", addr, 0);
    chk("R11 len", len, 0);
    chk("R11 flags", {done, ok, pid_err, crc_err}, 0);
  endtask

  task automatic t_good();
    do_reset();
    fill(3);
    push(13'h1A5B, 13);
    build(32'hDEADBEEF, 5, 8'h1E, 8'h2D, 0, 0);
    send();
    chk("R1 R6 done", done_cnt, 1);
    chk("R6 ok", last_ok, 1);
    chk("R3 addr", addr, 32'hDEADBEEF);
    chk("R3 len", len, 5);
    chk("R4 writes", wr_cnt, 5);
    for (int i = 0; i < 5; i++) chk("R4 R5 byte", seen[i], pay[i]);
    chk("R5 flags", {pid_err, crc_err}, 0);
  endtask

  task automatic t_partial_sync();
    do_reset();
    fill(9);
    push(32'hAAAA5555 >> 1, 31);
    push(8'h1E, 8);
    tcrc = 16'hFFFF;
    pushc(32'h12345678, 32);
    pushc(2, 16);
    push(tcrc, 16);
    send();
    chk("R1 no frame", done_cnt, 0);
    chk("R1 addr kept", addr, 0);
  endtask

  task automatic t_zero_len();
    do_reset();
    build(32'h0000_00A5, 0, 8'h1E, 8'h2D, 0, 0);
    send();
    chk("R10 done", done_cnt, 1);
    chk("R10 ok", last_ok, 1);
    chk("R10 writes", wr_cnt, 0);
  endtask

  task automatic t_bad_pid();
    do_reset();
    push(32'hAAAA5555, 32);
    push(8'h1F, 8);
    send();
    chk("R2 flag", pid_err, 1);
    chk("R2 no done", done_cnt, 0);
    fill(5);
    build(32'hCAFE0001, 3, 8'h1E, 8'h2C, 0, 0);
    send();
    chk("R2 data pid no done", done_cnt, 0);
    chk("R2 data pid no write", wr_cnt, 0);
    build(32'hCAFE0002, 3, 8'h1E, 8'h2D, 0, 0);
    send();
    chk("R2 recover", done_cnt, 1);
    chk("R2 recover ok", last_ok, 1);
    chk("R2 sticky", pid_err, 1);
  endtask

  task automatic t_sof_crc();
    do_reset();
    fill(1);
    build(32'h1111_2222, 2, 8'h1E, 8'h2D, 0, 0);
    send();
    clear_obs();
    build(32'h3333_4444, 6, 8'h1E, 8'h2D, 16'h0001, 0);
    send();
    chk("R8 done", done_cnt, 1);
    chk("R8 not ok", last_ok, 0);
    chk("R8 crc flag", crc_err, 1);
    chk("R8 no writes", wr_cnt, 0);
    chk("R8 addr kept", addr, 32'h1111_2222);
    chk("R8 len kept", len, 2);
  endtask

  task automatic t_dat_crc();
    do_reset();
    fill(77);
    build(32'h5555_0000, 4, 8'h1E, 8'h2D, 0, 16'h8000);
    send();
    chk("R7 done", done_cnt, 1);
    chk("R7 not ok", last_ok, 0);
    chk("R7 crc flag", crc_err, 1);
    chk("R7 writes kept", wr_cnt, 4);
    chk("R7 byte3", seen[3], pay[3]);
    fill(8);
    clear_obs();
    build(32'h5555_0001, 1, 8'h1E, 8'h2D, 0, 0);
    send();
    chk("R7 sticky", crc_err, 1);
    chk("R7 next ok", last_ok, 1);
  endtask

  task automatic t_wrong_type();
    do_reset();
    fill(4);
    build(32'h7777_0000, 3, 8'h1E, 8'h1E, 0, 0);
    send();
    build(32'h7777_0001, 3, 8'h2D, 8'h2D, 0, 0);
    send();
    chk("R9 no done", done_cnt, 0);
    chk("R9 no writes", wr_cnt, 0);
    chk("R9 no flags", {pid_err, crc_err}, 0);
    build(32'h7777_0002, 3, 8'h1E, 8'h2D, 0, 0);
    send();
    chk("R9 recover", done_cnt, 1);
    chk("R9 addr", addr, 32'h7777_0002);
  endtask

  initial begin
    t_reset();
    t_good();
    t_partial_sync();
    t_zero_len();
    t_bad_pid();
    t_sof_crc();
    t_dat_crc();
    t_wrong_type();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule